// File: doc/BRIEF.md
# Four-State Phase-Alternating AND Word

This block computes the bitwise AND of two words whose bits are carried in four-state logic. Each bit travels on two rails, and each logic value has two legal codes, one per phase. Successive data waves alternate phase, so one wave is told apart from the next by its phase change alone. No empty spacer word is needed between them.

Each output bit is a holding element. It takes a new value only when both of its operand bits have arrived in the same phase and that phase differs from the phase the bit already holds. In every other case it keeps its last valid code. A word-level completion signal reports when every output bit carries the same phase. A jump flag reports an operand bit that moved between the two codes of one phase, because that move flips both rails at once.

The block is clocked and reset synchronously. It is meant for the register-level modelling of a delay-insensitive datapath stage, with `WIDTH` gates side by side.

Top module: `fsl_and_word`

## Requirements
- R1: Rail encoding per bit. The value rail `*_val` holds the logic value, and the phase equals `*_val ^ *_par`. This gives phase-0 low = val 0 / par 0, phase-0 high = 1/1, phase-1 low = 0/1, phase-1 high = 1/0. While `rst` is high at a clock edge, every output bit is set to phase-1 low (`z_val` all 0, `z_par` all 1), `jump_err` is cleared, and `word_done` reads 1.
- R2: If both operand bits are in phase 0 and the output bit holds phase 1, the next clock edge loads the phase-0 code of the AND: high only when both operand values are 1.
- R3: If both operand bits are in phase 1 and the output bit holds phase 0, the next clock edge loads the phase-1 code of the AND of the two operand values.
- R4: If the two operand bits of a position are in different phases, that output bit keeps its code across the clock edge.
- R5: If both operand bits are in the phase the output bit already holds, the output bit keeps its code across the clock edge, whatever the operand values.
- R6: `word_done` is 1 exactly when all `WIDTH` output bits hold the same phase. It is 0 while some bits have moved to the new phase and others have not.
- R7: With the default `STICKY_ERR=0`, `jump_err` is high for the one cycle after a clock edge at which some operand bit has both rails changed since the operand was sampled at the previous edge. The first edge after reset is never flagged. With `STICKY_ERR=1`, the flag stays set until reset.
- R8: Bit positions are independent. One position's inputs never change another position's output code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| x_val | input | WIDTH | Operand X, value rail per bit |
| x_par | input | WIDTH | Operand X, phase-mixed rail per bit |
| y_val | input | WIDTH | Operand Y, value rail per bit |
| y_par | input | WIDTH | Operand Y, phase-mixed rail per bit |
| z_val | output | WIDTH | Result, value rail per bit |
| z_par | output | WIDTH | Result, phase-mixed rail per bit |
| word_done | output | 1 | All result bits hold one phase |
| jump_err | output | 1 | Operand bit changed both rails between samples |

## Verification
A held phase that is wrong inside a cell shows up one edge later, in either of two ways. The bit refuses a legal new wave, so its output stays stale while its neighbours advance and `word_done` drops. Or the bit accepts a wave of its own phase, so the output code changes where it should hold. A damaged previous-sample register shows on `jump_err` in the cycle after the offending edge, either as a spurious pulse or as a missing one. The sweep steps through every operand value pair in both phases, so a wrong AND term or a swapped rail fails on the first wave that uses it.

// File: rtl/fsl_and_pkg.sv
package fsl_and_pkg;

   // one dual-rail bit: value rail and phase-mixed rail
   typedef struct packed {
      logic val;
      logic par;
   } fsl_code_t;

   // code held by every result bit after reset: phase 1, logic low
   localparam fsl_code_t FSL_RESET_CODE = '{val: 1'b0, par: 1'b1};

   function automatic logic fsl_phase(input fsl_code_t c);
      return c.val ^ c.par;
   endfunction

   function automatic fsl_code_t fsl_encode(input logic v, input logic ph);
      fsl_code_t c;
      c.val = v;
      c.par = v ^ ph;
      return c;
   endfunction

endpackage

// File: rtl/fsl_and_cell.sv
module fsl_and_cell
   import fsl_and_pkg::*;
(
   input  logic      clk,
   input  logic      rst,
   input  fsl_code_t op_x,
   input  fsl_code_t op_y,
   output fsl_code_t res
);

   fsl_code_t held_q;
   logic      ph_x, ph_y, same_ph, new_wave;

   always_comb begin
      ph_x     = fsl_phase(op_x);
      ph_y     = fsl_phase(op_y);
      same_ph  = (ph_x == ph_y);
      new_wave = same_ph && (ph_x != fsl_phase(held_q));
   end

   always_ff @(posedge clk) begin
      if (rst)
         held_q <= FSL_RESET_CODE;
      else if (new_wave)
         held_q <= fsl_encode(op_x.val & op_y.val, ph_x);
   end

   assign res = held_q;

endmodule

// File: rtl/fsl_jump_monitor.sv
module fsl_jump_monitor #(
   parameter int WIDTH = 4
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [WIDTH-1:0] mon_val,
   input  logic [WIDTH-1:0] mon_par,
   output logic             jump
);

   logic [WIDTH-1:0] prev_val_q, prev_par_q;
   logic             primed_q;
   logic [WIDTH-1:0] both_flip;

   always_ff @(posedge clk) begin
      prev_val_q <= mon_val;
      prev_par_q <= mon_par;
      primed_q   <= !rst;
   end

   always_comb begin
      both_flip = (mon_val ^ prev_val_q) & (mon_par ^ prev_par_q);
      jump      = primed_q && (|both_flip);
   end

endmodule

// File: rtl/fsl_word_complete.sv
module fsl_word_complete
   import fsl_and_pkg::*;
#(
   parameter int WIDTH = 4
) (
   input  fsl_code_t [WIDTH-1:0] codes,
   output logic                  complete
);

   logic [WIDTH-1:0] ph;

   for (genvar i = 0; i < WIDTH; i++) begin : g_ph
      assign ph[i] = fsl_phase(codes[i]);
   end

   assign complete = (&ph) | ~(|ph);

endmodule

// File: rtl/fsl_and_word.sv
module fsl_and_word
   import fsl_and_pkg::*;
#(
   parameter int WIDTH      = 4,
   parameter bit STICKY_ERR = 1'b0
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [WIDTH-1:0] x_val,
   input  logic [WIDTH-1:0] x_par,
   input  logic [WIDTH-1:0] y_val,
   input  logic [WIDTH-1:0] y_par,
   output logic [WIDTH-1:0] z_val,
   output logic [WIDTH-1:0] z_par,
   output logic             word_done,
   output logic             jump_err
);

   localparam int MON_W = 2 * WIDTH;

   if (WIDTH < 1) begin : g_width_chk
      $error("fsl_and_word: WIDTH must be at least 1");
   end

   fsl_code_t [WIDTH-1:0] res;
   logic                  jump;

   for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      fsl_code_t cx, cy;
      assign cx = '{val: x_val[i], par: x_par[i]};
      assign cy = '{val: y_val[i], par: y_par[i]};

      fsl_and_cell cell_i (
         .clk  (clk),
         .rst  (rst),
         .op_x (cx),
         .op_y (cy),
         .res  (res[i])
      );

      assign z_val[i] = res[i].val;
      assign z_par[i] = res[i].par;
   end

   fsl_word_complete #(.WIDTH(WIDTH)) done_i (
      .codes    (res),
      .complete (word_done)
   );

   fsl_jump_monitor #(.WIDTH(MON_W)) mon_i (
      .clk     (clk),
      .rst     (rst),
      .mon_val ({y_val, x_val}),
      .mon_par ({y_par, x_par}),
      .jump    (jump)
   );

   if (STICKY_ERR) begin : g_err_sticky
      always_ff @(posedge clk) begin
         if (rst)       jump_err <= 1'b0;
         else if (jump) jump_err <= 1'b1;
      end
   end else begin : g_err_pulse
      always_ff @(posedge clk) begin
         if (rst) jump_err <= 1'b0;
         else     jump_err <= jump;
      end
   end

endmodule

// File: rtl/fsl_and_word_chk.sv
module fsl_and_word_chk #(
   parameter int WIDTH      = 4,
   parameter bit STICKY_ERR = 1'b0
) (
   input logic             clk,
   input logic             rst,
   input logic [WIDTH-1:0] x_val,
   input logic [WIDTH-1:0] x_par,
   input logic [WIDTH-1:0] y_val,
   input logic [WIDTH-1:0] y_par,
   input logic [WIDTH-1:0] z_val,
   input logic [WIDTH-1:0] z_par,
   input logic             word_done,
   input logic             jump_err
);

   logic [WIDTH-1:0] xph, yph, zph;
   logic [WIDTH-1:0] sx_v, sx_p, sy_v, sy_p;
   logic             seen_q, dbl;
   logic             all_enter;

   always_comb begin
      xph = x_val ^ x_par;
      yph = y_val ^ y_par;
      zph = z_val ^ z_par;
      dbl = seen_q && (|(((x_val ^ sx_v) & (x_par ^ sx_p)) |
                         ((y_val ^ sy_v) & (y_par ^ sy_p))));
      all_enter = (xph == yph) && (xph == ~zph) && ((&xph) || !(|xph));
   end

   always_ff @(posedge clk) begin
      sx_v   <= x_val;
      sx_p   <= x_par;
      sy_v   <= y_val;
      sy_p   <= y_par;
      seen_q <= !rst;
   end

   assert_reset_code_R1: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (z_val == '0 && z_par == '1 && word_done && !jump_err));

   // R6: a whole word entering a fresh phase completes one edge later
   assert_word_done_R6: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && $past(all_enter)) |-> word_done);

   if (!STICKY_ERR) begin : g_pulse_chk
      assert_jump_pulse_R7: assert property (@(posedge clk) disable iff (rst)
         !$past(rst) |-> (jump_err == $past(dbl)));
   end

   for (genvar i = 0; i < WIDTH; i++) begin : g_bit_chk
      // R4: operand phases disagree -> hold
      assert_hold_mismatch_R4: assert property (@(posedge clk) disable iff (rst)
         (!$past(rst) && $past(xph[i] != yph[i]))
         |-> ($stable(z_val[i]) && $stable(z_par[i])));
      // R5: operands in the phase already held -> hold
      assert_hold_same_R5: assert property (@(posedge clk) disable iff (rst)
         (!$past(rst) && $past(xph[i] == yph[i] && xph[i] == zph[i]))
         |-> ($stable(z_val[i]) && $stable(z_par[i])));
      // R2 and R3: new wave loads the AND in the operands' phase
      assert_load_and_R2_R3: assert property (@(posedge clk) disable iff (rst)
         (!$past(rst) && $past(xph[i] == yph[i] && xph[i] != zph[i]))
         |-> (z_val[i] == $past(x_val[i] & y_val[i]) && zph[i] == $past(xph[i])));
   end

endmodule

bind fsl_and_word fsl_and_word_chk #(.WIDTH(WIDTH), .STICKY_ERR(STICKY_ERR)) chk_i (
   .clk       (clk),
   .rst       (rst),
   .x_val     (x_val),
   .x_par     (x_par),
   .y_val     (y_val),
   .y_par     (y_par),
   .z_val     (z_val),
   .z_par     (z_par),
   .word_done (word_done),
   .jump_err  (jump_err)
);

// File: tb/fsl_and_word_tb_top.sv
module fsl_and_word_tb_top;

   localparam int W = 2;

   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic [W-1:0] x_val, x_par, y_val, y_par;
   logic [W-1:0] z_val, z_par;
   logic         word_done, jump_err;

   int total = 0;
   int bad   = 0;
   bit over  = 1'b0;

   always #2 clk = ~clk;

   fsl_and_word #(.WIDTH(W), .STICKY_ERR(1'b0)) dut_i (
      .clk       (clk),
      .rst       (rst),
      .x_val     (x_val),
      .x_par     (x_par),
      .y_val     (y_val),
      .y_par     (y_par),
      .z_val     (z_val),
      .z_par     (z_par),
      .word_done (word_done),
      .jump_err  (jump_err)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic check_z(input string req, input logic [W-1:0] ev, input logic [W-1:0] ep);
      check(z_val == ev && z_par == ep, req, {z_val, z_par}, {ev, ep});
   endtask

   // drive operands: value and per-bit phase mask
   task automatic drive(input logic [W-1:0] xv, input logic [W-1:0] xp,
                        input logic [W-1:0] yv, input logic [W-1:0] yp);
      x_val = xv; x_par = xv ^ xp;
      y_val = yv; y_par = yv ^ yp;
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   initial begin
      drive('1, '1, '1, '1);           // phase-1 high on all bits
      repeat (3) @(negedge clk);
      rst = 1'b0;
      // R1 reset code: phase-1 low, done high, no error
      check_z("R1", '0, '1);
      check(word_done == 1'b1, "R1", word_done, 1);
      check(jump_err == 1'b0, "R1", jump_err, 0);
      // R5: operands already in the held phase -> no update
      step();
      check_z("R5", '0, '1);
      check(jump_err == 1'b0, "R7", jump_err, 0);

      // R2/R3 sweep: every value pair in both phases, phases alternating
      for (int k = 0; k < 32; k++) begin
         logic [W-1:0] xv, yv, ev, pm;
         xv = k[2:1];
         yv = k[4:3];
         pm = {W{k[0]}};
         ev = xv & yv;
         drive(xv, pm, yv, pm);
         step();
         check_z(k[0] ? "R3" : "R2", ev, ev ^ pm);
         check(word_done == 1'b1, "R6", word_done, 1);
         check(jump_err == 1'b0, "R7", jump_err, 0);
      end

      // R4: X moves to phase 0, Y stays in phase 1 -> hold
      drive(2'b11, 2'b00, 2'b11, 2'b11);
      step();
      check_z("R4", 2'b11, 2'b00);
      drive(2'b11, 2'b00, 2'b01, 2'b00);
      step();
      check_z("R2", 2'b01, 2'b01);

      // R6 / R8: only bit 0 moves to phase 1
      drive(2'b11, 2'b01, 2'b01, 2'b01);
      step();
      check_z("R8", 2'b01, 2'b00);
      check(word_done == 1'b0, "R6", word_done, 0);
      drive(2'b11, 2'b11, 2'b01, 2'b11);
      step();
      check_z("R8", 2'b01, 2'b10);
      check(word_done == 1'b1, "R6", word_done, 1);

      // R7: X bit 0 jumps phase-1 high -> phase-1 low (both rails flip)
      drive(2'b10, 2'b11, 2'b01, 2'b11);
      step();
      check(jump_err == 1'b1, "R7", jump_err, 1);
      check_z("R5", 2'b01, 2'b10);
      step();
      check(jump_err == 1'b0, "R7", jump_err, 0);

      // R1: reset mid-run restores the reset code
      rst = 1'b1;
      step();
      rst = 1'b0;
      check_z("R1", '0, '1);
      check(jump_err == 1'b0, "R1", jump_err, 0);

      over = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!over) begin
         total++;
         bad++;
         $display("FAIL watchdog actual=0 expected=1");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule